// File: doc/BRIEF.md
# Serial Receiver with Interrupting Receive Queue

This block is the receive half of an asynchronous serial port. It samples a serial line using a one-cycle enable pulse that arrives sixteen times per bit period. Each character it receives is placed in a 16-entry queue along with flags that describe how the character arrived. The line is idle high and each frame is sent least significant bit first. A frame holds 5 to 8 data bits, an optional parity bit that is either even or odd, and one stop bit. The bit-rate divisor that produces the oversampling pulse is outside this block.

A host uses a single-cycle register port to set up the character format, the receive enables, the fill threshold, the idle timeout and the interrupt masks. The host drains the queue by reading the data register, one entry per read. Three interrupt causes exist:

- overrun, which is sticky until the queue is reset;
- fill level above the threshold;
- data left unread for a number of whole character times.

Each cause has its own status bit and its own mask bit. The `irq` output is the OR of all unmasked causes.

Top module: `uart_rx_irq`

## Requirements
- R1: The data register at address 2 returns one entry per read and removes it from the queue. The entry layout is: character right-aligned in [7:0] with the unused upper bits zero, break flag [8], parity error [9], framing error [10], valid [11]. Bits arrive LSB first. The character length is 5 + CTRL[3:2], so code 0 gives 5 bits and code 3 gives 8 bits.
- R2: When CTRL[4] is set, a parity bit follows the data. CTRL[5]=0 selects even parity and CTRL[5]=1 selects odd parity. A mismatch sets the parity error flag.
- R3: A stop bit sampled low sets the framing error flag.
- R4: A frame that samples low in every bit, stop bit included, is stored as exactly one entry: character 0, break=1, framing=1, parity=0. Nothing more is stored until the line has returned high.
- R5: The start bit is checked again at mid-bit. A low pulse shorter than half a bit stores nothing.
- R6: The queue holds 16 entries. A character that arrives while the queue is full is discarded, the existing contents are kept, and overrun status (IRQ[8]) is set.
- R7: Reading data does not clear overrun status. Writing CTRL with bit 31 set empties the queue and clears overrun status.
- R8: Threshold status (IRQ[9]) is 1 exactly when the fill count is greater than the threshold field CTRL[16:12].
- R9: The timeout field is CTRL[11:8] and a value of 0 disables it. Timeout status (IRQ[10]) is set once the queue has been non-empty with no push and no pop for that many whole character times. A character time is (frame bits) × 16 oversample pulses. A pop clears the status.
- R10: `irq` is high exactly when at least one status bit is set and its mask bit is also set. The mask bits are IRQ[2:0], in the same cause order as the status bits.
- R11: The receiver runs only when both the receive enable CTRL[0] and the rate enable CTRL[1] are set. When either is clear, line activity stores nothing.
- R12: IRQ[12] shows that the queue is non-empty. A data read of an empty queue returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversample enable pulse, 16 per bit |
| rxIn | input | 1 | Serial line, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a data read pops the queue |
| regAddr | input | 2 | 0 control, 1 interrupt, 2 data |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the same cycle as regRdEn |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is overrun. Getting there takes seventeen complete frames with no read in between. The bench then has to drain the queue and show that all sixteen stored characters are intact and in order, while the status bit stays set until the reset write. The break case is also hard to reach, because it needs the line held low for several frame times and then a clean frame afterwards, to prove that exactly one entry was stored. A behavioural model tracks the expected queue contents and compares the interrupt line on every cycle while the line is idle.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int ENTRY_W = 12;

  typedef struct packed {
    logic frameStart;
    logic shiftBit;
    logic sampParity;
    logic finish;
    logic pop;
    logic flush;
  } rx_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_BRKWAIT
  } rx_state_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_IRQ  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

endpackage

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int PTR_W = $clog2(FIFO_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  rx_strobe_t         stb,
  input  logic               rxBit,
  input  logic [1:0]         dataCode,
  input  logic               parEn,
  input  logic               parOdd,
  output logic [CNT_W-1:0]   fillCount,
  output logic               ovrFlag,
  output logic               frameIsBreak,
  output logic [ENTRY_W-1:0] headEntry
);

  logic [7:0]         shReg;
  logic               parAcc;
  logic               anyHigh;
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [ENTRY_W-1:0] mem [FIFO_DEPTH];
  logic [7:0]         charVal;
  logic               parErr, frameErr, isFull, doPush, doPop;
  logic [ENTRY_W-1:0] newEntry;

  // Frame assembly: shift in from the top, right-align at the end.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      parAcc  <= 1'b0;
      anyHigh <= 1'b0;
    end else if (stb.frameStart) begin
      shReg   <= '0;
      parAcc  <= 1'b0;
      anyHigh <= 1'b0;
    end else if (stb.shiftBit) begin
      shReg   <= {rxBit, shReg[7:1]};
      parAcc  <= parAcc ^ rxBit;
      anyHigh <= anyHigh | rxBit;
    end else if (stb.sampParity) begin
      parAcc  <= parAcc ^ rxBit;
      anyHigh <= anyHigh | rxBit;
    end
  end

  assign frameIsBreak = !anyHigh && !rxBit;
  assign charVal      = shReg >> (2'd3 - dataCode);
  assign frameErr     = !rxBit;
  assign parErr       = parEn && !frameIsBreak && (parAcc != parOdd);
  assign newEntry     = {1'b1, frameErr, parErr, frameIsBreak, charVal};

  assign isFull = (fillCount == CNT_W'(FIFO_DEPTH));
  assign doPush = stb.finish && !stb.flush && !isFull;
  assign doPop  = stb.pop && !stb.flush && (fillCount != '0);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
      ovrFlag   <= 1'b0;
    end else if (stb.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
      ovrFlag   <= 1'b0;
    end else begin
      if (stb.finish && isFull) ovrFlag <= 1'b1;
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  assign headEntry = (fillCount != '0) ? mem[rdPtr] : '0;

endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OVS = 16,
  parameter int TO_W = 4,
  parameter int REG_W = 32,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int PH_W = $clog2(OVS),
  localparam int TICK_W = $clog2(11 * OVS + 1),
  localparam int THR_LSB = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick16,
  input  logic               rxIn,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [1:0]         regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic               irq,
  input  logic [CNT_W-1:0]   fillCount,
  input  logic               ovrFlag,
  input  logic               frameIsBreak,
  input  logic [ENTRY_W-1:0] headEntry,
  output rx_strobe_t         stb,
  output logic               rxBit,
  output logic [1:0]         dataCode,
  output logic               parEn,
  output logic               parOdd,
  output logic               toStatus
);

  localparam logic [PH_W-1:0]   PH_LAST = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0]   PH_MID  = PH_W'(OVS / 2 - 1);
  localparam logic [TICK_W-1:0] OVS_T   = TICK_W'(OVS);

  logic              rxMeta;
  logic              rxEn, rateEn;
  logic [TO_W-1:0]   toField;
  logic [CNT_W-1:0]  thrField;
  logic [2:0]        irqMask;
  rx_state_t         state;
  logic [PH_W-1:0]   phase;
  logic [2:0]        bitIdx;
  logic              active, phWrap, lastData;
  logic [TICK_W-1:0] tickCnt, charTicks;
  logic [TO_W-1:0]   charCnt;
  logic [3:0]        frameBits;
  logic              toRestart, thrStatus;
  logic [2:0]        status;
  logic              wrCtrl, wrIrq;
  logic              unusedWr;

  // Two-flop synchronizer for the asynchronous line.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxBit  <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxBit  <= rxMeta;
    end
  end

  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign wrIrq  = regWrEn && (regAddr == ADDR_IRQ);
  assign unusedWr = ^{regWrData[REG_W-2:THR_LSB+CNT_W], regWrData[7:6], regWrData[REG_W-1:3]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEn     <= 1'b0;
      rateEn   <= 1'b0;
      dataCode <= '0;
      parEn    <= 1'b0;
      parOdd   <= 1'b0;
      toField  <= '0;
      thrField <= '0;
      irqMask  <= '0;
    end else begin
      if (wrCtrl) begin
        rxEn     <= regWrData[0];
        rateEn   <= regWrData[1];
        dataCode <= regWrData[3:2];
        parEn    <= regWrData[4];
        parOdd   <= regWrData[5];
        toField  <= regWrData[8 +: TO_W];
        thrField <= regWrData[THR_LSB +: CNT_W];
      end
      if (wrIrq) irqMask <= regWrData[2:0];
    end
  end

  // Frame sequencing on oversample pulses.
  assign active   = rxEn && rateEn;
  assign phWrap   = (phase == PH_LAST);
  assign lastData = (bitIdx == (3'd4 + {1'b0, dataCode}));

  always_comb begin
    stb = '0;
    if (tick16 && active) begin
      case (state)
        ST_IDLE:   stb.frameStart = !rxBit;
        ST_DATA:   stb.shiftBit   = phWrap;
        ST_PARITY: stb.sampParity = phWrap;
        ST_STOP:   stb.finish     = phWrap;
        default:   ;
      endcase
    end
    stb.pop   = regRdEn && (regAddr == ADDR_DATA) && (fillCount != '0);
    stb.flush = wrCtrl && regWrData[REG_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (!active) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (tick16) begin
      phase <= phase + 1'b1;
      case (state)
        ST_IDLE: begin
          phase <= '0;
          if (!rxBit) state <= ST_START;
        end
        ST_START: begin
          if (phase == PH_MID) begin
            phase  <= '0;
            bitIdx <= '0;
            state  <= rxBit ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (phWrap) begin
            bitIdx <= bitIdx + 1'b1;
            if (lastData) state <= parEn ? ST_PARITY : ST_STOP;
          end
        end
        ST_PARITY: if (phWrap) state <= ST_STOP;
        ST_STOP:   if (phWrap) state <= frameIsBreak ? ST_BRKWAIT : ST_IDLE;
        ST_BRKWAIT: begin
          phase <= '0;
          if (rxBit) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Idle timeout measured in whole character times.
  assign frameBits = 4'd7 + {2'b00, dataCode} + {3'b000, parEn};
  assign charTicks = TICK_W'(frameBits) * OVS_T;
  assign toRestart = stb.finish || stb.pop || stb.flush || (fillCount == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      charCnt <= '0;
    end else if (toRestart) begin
      tickCnt <= '0;
      charCnt <= '0;
    end else if (tick16 && rateEn) begin
      if (tickCnt == charTicks - 1'b1) begin
        tickCnt <= '0;
        if (charCnt != '1) charCnt <= charCnt + 1'b1;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  assign toStatus  = (toField != '0) && (charCnt >= toField) && (fillCount != '0);
  assign thrStatus = (fillCount > thrField);
  assign status    = {toStatus, thrStatus, ovrFlag};
  assign irq       = |(status & irqMask);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[0]                 = rxEn;
        regRdData[1]                 = rateEn;
        regRdData[3:2]               = dataCode;
        regRdData[4]                 = parEn;
        regRdData[5]                 = parOdd;
        regRdData[8 +: TO_W]         = toField;
        regRdData[THR_LSB +: CNT_W]  = thrField;
      end
      ADDR_IRQ: begin
        regRdData[2:0]  = irqMask;
        regRdData[10:8] = status;
        regRdData[12]   = (fillCount != '0);
      end
      ADDR_DATA: regRdData[ENTRY_W-1:0] = headEntry;
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OVS = 16,
  parameter int TO_W = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick16,
  input  logic        rxIn,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irq
);

  rx_strobe_t         stb;
  logic               rxBit, parEn, parOdd, ovrFlag, frameIsBreak, toStatus;
  logic [1:0]         dataCode;
  logic [CNT_W-1:0]   fillCount;
  logic [ENTRY_W-1:0] headEntry;

  uart_rx_ctrl #(
    .FIFO_DEPTH(FIFO_DEPTH), .OVS(OVS), .TO_W(TO_W), .REG_W(32)
  ) u_ctrl (
    .clk, .rstN, .tick16, .rxIn, .regWrEn, .regRdEn, .regAddr, .regWrData,
    .regRdData, .irq, .fillCount, .ovrFlag, .frameIsBreak, .headEntry,
    .stb, .rxBit, .dataCode, .parEn, .parOdd, .toStatus
  );

  uart_rx_path #(.FIFO_DEPTH(FIFO_DEPTH)) u_path (
    .clk, .rstN, .stb, .rxBit, .dataCode, .parEn, .parOdd,
    .fillCount, .ovrFlag, .frameIsBreak, .headEntry
  );

endmodule

// File: rtl/uart_rx_irq_checker.sv
module uart_rx_irq_checker
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input rx_strobe_t       stb,
  input logic [CNT_W-1:0] fillCount,
  input logic             ovrFlag,
  input logic             toStatus
);

  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(FIFO_DEPTH));

  assert_full_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == CNT_W'(FIFO_DEPTH)) && !stb.pop && !stb.flush
      |=> fillCount == CNT_W'(FIFO_DEPTH));

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag && !stb.flush |=> ovrFlag);

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> (fillCount == '0) && !ovrFlag);

  assert_pop_shrinks_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop && !stb.finish && !stb.flush |=> fillCount == CNT_W'($past(fillCount) - 1'b1));

  assert_pop_clears_timeout_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |=> !toStatus);

endmodule

bind uart_rx_irq uart_rx_irq_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .fillCount(fillCount),
  .ovrFlag(ovrFlag), .toStatus(toStatus)
);

// File: tb/uart_rx_irq_bench.sv
module uart_rx_irq_bench;

  localparam int BITCLK = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick16 = 1'b0;
  logic        rxIn = 1'b1;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int q[$];
  bit ovrM = 0;
  int thrM = 0;
  bit [2:0] maskM = 0;
  bit cmpOn = 0;
  bit done = 0;
  logic [1:0] tickDiv = '0;

  uart_rx_irq u_uart_rx_irq (
    .clk, .rstN, .tick16, .rxIn, .regWrEn, .regRdEn, .regAddr,
    .regWrData, .regRdData, .irq
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tickDiv <= tickDiv + 1'b1;
    tick16  <= (tickDiv == 2'd3);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R10: irq compared against the model on every cycle while idle.
  always @(posedge clk) begin
    #2;
    if (cmpOn && rstN) begin
      automatic bit thrS = (q.size() > thrM);
      check("R10 irq per-cycle", int'(irq), int'(|({1'b0, thrS, ovrM} & maskM)));
    end
  end

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    #1;
    if (a == 2'd1) maskM = d[2:0];
    if (a == 2'd0) begin
      thrM = int'(d[16:12]);
      if (d[31]) begin q.delete(); ovrM = 0; end
    end
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1; regAddr = a;
    #1;
    d = regRdData;
    if (a == 2'd2 && q.size() > 0) void'(q.pop_front());
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic expectData(input string req);
    logic [31:0] d;
    int exp;
    exp = (q.size() > 0) ? q[0] : 0;
    regRead(2'd2, d);
    check(req, int'(d), exp);
  endtask

  task automatic sendFrame(input int data, input int nbits, input bit par,
                           input bit odd, input bit badPar, input int stopLow);
    bit p;
    p = odd ^ badPar;
    rxIn = 0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rxIn = data[i];
      p ^= data[i];
      repeat (BITCLK) @(negedge clk);
    end
    if (par) begin
      rxIn = p;
      repeat (BITCLK) @(negedge clk);
    end
    if (stopLow > 0) begin
      rxIn = 0;
      repeat (stopLow) @(negedge clk);
      rxIn = 1;
      repeat (BITCLK) @(negedge clk);
    end else begin
      rxIn = 1;
      repeat (BITCLK) @(negedge clk);
    end
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic rxChar(input int data, input int nbits, input bit par, input bit odd,
                        input bit badPar, input int stopLow, input bit store);
    int ent;
    cmpOn = 0;
    sendFrame(data, nbits, par, odd, badPar, stopLow);
    ent = 32'h800 | (data & ((1 << nbits) - 1));
    if (par && badPar) ent |= 32'h200;
    if (stopLow > 0) ent |= 32'h400;
    if (store) begin
      if (q.size() >= 16) ovrM = 1;
      else q.push_back(ent);
    end
    cmpOn = 1;
  endtask

  function automatic logic [31:0] ctrlWord(input int code, input bit pe, input bit po,
                                           input int to, input int thr, input bit en);
    return {1'b0, 14'd0, 5'(thr), 4'(to), 2'b00, po, pe, 2'(code), en, en};
  endfunction

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);

    regRead(2'd0, d); check("R11 reset ctrl", int'(d), 0);
    regRead(2'd1, d); check("R12 reset irq reg", int'(d), 0);
    expectData("R12 empty read at reset");
    check("R10 reset irq", int'(irq), 0);
    cmpOn = 1;

    regWrite(2'd0, ctrlWord(3, 0, 0, 0, 31, 1));
    rxChar(8'hA5, 8, 0, 0, 0, 0, 1);
    regRead(2'd1, d); check("R12 not-empty bit", int'(d[12]), 1);
    expectData("R1 8-bit char");
    regRead(2'd1, d); check("R12 empty after pop", int'(d[12]), 0);

    regWrite(2'd0, ctrlWord(0, 0, 0, 0, 31, 1));
    rxChar(8'hF3, 5, 0, 0, 0, 0, 1);
    expectData("R1 5-bit char right aligned");

    regWrite(2'd0, ctrlWord(2, 1, 0, 0, 31, 1));
    rxChar(8'h55, 7, 1, 0, 0, 0, 1);
    expectData("R2 even parity good");
    rxChar(8'h55, 7, 1, 0, 1, 0, 1);
    expectData("R2 even parity bad");
    regWrite(2'd0, ctrlWord(2, 1, 1, 0, 31, 1));
    rxChar(8'h2A, 7, 1, 1, 0, 0, 1);
    expectData("R2 odd parity good");
    rxChar(8'h2B, 7, 1, 1, 1, 0, 1);
    expectData("R2 odd parity bad");

    regWrite(2'd0, ctrlWord(3, 0, 0, 0, 31, 1));
    rxChar(8'hFF, 8, 0, 0, 0, 48, 1);
    expectData("R3 framing error");
    expectData("R3 no extra entry");

    // R4: line held low for several frames.
    cmpOn = 0;
    rxIn = 0;
    repeat (2200) @(negedge clk);
    rxIn = 1;
    repeat (200) @(negedge clk);
    q.push_back(32'hD00);
    cmpOn = 1;
    expectData("R4 single break entry");
    expectData("R4 nothing after break");
    rxChar(8'h3C, 8, 0, 0, 0, 0, 1);
    expectData("R4 clean frame after break");

    // R5: short low pulse.
    rxIn = 0; repeat (20) @(negedge clk); rxIn = 1;
    repeat (800) @(negedge clk);
    expectData("R5 glitch rejected");

    // R11: gating by each enable.
    regWrite(2'd0, 32'h0000_000E);
    rxChar(8'h11, 8, 0, 0, 0, 0, 0);
    expectData("R11 rx enable clear");
    regWrite(2'd0, 32'h0000_000D);
    rxChar(8'h22, 8, 0, 0, 0, 0, 0);
    expectData("R11 rate enable clear");

    // R8 / R10: threshold.
    regWrite(2'd0, ctrlWord(3, 0, 0, 0, 2, 1));
    regWrite(2'd1, 32'h2);
    rxChar(8'h01, 8, 0, 0, 0, 0, 1);
    rxChar(8'h02, 8, 0, 0, 0, 0, 1);
    regRead(2'd1, d); check("R8 count equal threshold", int'(d[9]), 0);
    check("R10 irq low at threshold", int'(irq), 0);
    rxChar(8'h03, 8, 0, 0, 0, 0, 1);
    regRead(2'd1, d); check("R8 count above threshold", int'(d[9]), 1);
    check("R10 irq high with mask", int'(irq), 1);
    expectData("R8 drain 1");
    regRead(2'd1, d); check("R8 back at threshold", int'(d[9]), 0);
    expectData("R8 drain 2");
    expectData("R8 drain 3");

    // R6 / R7: overrun.
    regWrite(2'd0, ctrlWord(3, 0, 0, 0, 16, 1));
    regWrite(2'd1, 32'h1);
    for (int i = 0; i < 17; i++) rxChar(i + 8'h40, 8, 0, 0, 0, 0, 1);
    regRead(2'd1, d); check("R6 overrun status", int'(d[8]), 1);
    check("R10 irq on overrun", int'(irq), 1);
    for (int i = 0; i < 16; i++) expectData("R6 contents intact");
    expectData("R6 discarded char absent");
    regRead(2'd1, d); check("R7 overrun survives reads", int'(d[8]), 1);
    regWrite(2'd0, ctrlWord(3, 0, 0, 0, 16, 1) | 32'h8000_0000);
    regRead(2'd1, d); check("R7 cleared by reset bit", int'(d[8]), 0);
    check("R10 irq low after reset", int'(irq), 0);

    // R9: timeout.
    cmpOn = 0;
    regWrite(2'd0, ctrlWord(3, 0, 0, 1, 16, 1));
    regWrite(2'd1, 32'h4);
    rxChar(8'h77, 8, 0, 0, 0, 0, 1);
    cmpOn = 0;
    repeat (200) @(negedge clk);
    regRead(2'd1, d); check("R9 not yet timed out", int'(d[10]), 0);
    repeat (500) @(negedge clk);
    regRead(2'd1, d); check("R9 timed out", int'(d[10]), 1);
    check("R10 irq on timeout", int'(irq), 1);
    expectData("R9 data after timeout");
    regRead(2'd1, d); check("R9 cleared by pop", int'(d[10]), 0);
    regWrite(2'd0, ctrlWord(3, 0, 0, 0, 16, 1));
    rxChar(8'h78, 8, 0, 0, 0, 0, 1);
    cmpOn = 0;
    repeat (2000) @(negedge clk);
    regRead(2'd1, d); check("R9 zero field disables", int'(d[10]), 0);
    expectData("R9 drain");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule